// File: doc/BRIEF.md
# Integer Compare-and-Set Unit

This unit sits in the execute stage of a 32-bit integer datapath. It evaluates one relation between two operands and writes a 32-bit flag word. The word is exactly 1 when the relation holds and 0 when it does not. The first operand always comes from a register. The second operand comes either from a register or from a 16-bit immediate. The immediate is widened to 32 bits by sign or zero extension, and the relation code selects which.

Six primitive relations are built in: equal, not-equal, signed and unsigned less-than, and signed and unsigned greater-or-equal. Greater-than and less-or-equal have no comparator of their own. A swap input exchanges the two operands after the immediate has been formed, so greater-than is less-than with the operands swapped, and less-or-equal is greater-or-equal with the operands swapped. The signed order is obtained from the two sign bits together with the unsigned result.

The flag word and its valid strobe are registered, so results appear one clock after the inputs are presented.

Top module: `cmpset_unit`

## Requirements
- R1: The result word is always either 0x00000001 or 0x00000000; bits 31..1 are never set.
- R2: Relation code 0 tests equality and code 1 tests inequality of the two evaluated operands.
- R3: Relation code 2 tests signed less-than and code 4 tests signed greater-or-equal, both treating the operands as two's complement; for example 0x80000000 < 0x00000001 is true under code 2.
- R4: Relation code 3 tests unsigned less-than and code 5 tests unsigned greater-or-equal; for example 0x80000000 < 0x00000001 is false under code 3.
- R5: When the immediate is selected with codes 0, 1, 2 or 4, the second operand is the 16-bit immediate sign-extended to 32 bits (0x8000 becomes 0xFFFF8000).
- R6: When the immediate is selected with codes 3 or 5, the second operand is the immediate zero-extended to 32 bits (0x8000 becomes 0x00008000).
- R7: When swap is high, the first and second operands are exchanged after the immediate is formed and before the relation is evaluated, so code 2 with swap computes A > B and code 4 with swap computes A <= B.
- R8: Relation codes 6 and 7 are unassigned and always produce a result of 0.
- R9: When in_valid is high at a rising edge, the result of those inputs appears on res at that edge and res_valid is high for exactly that following cycle. When in_valid is low, res keeps its value and res_valid is low.
- R10: A synchronous active-high reset clears res and res_valid to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are valid this cycle |
| rel | input | 3 | Relation code (0 eq, 1 ne, 2 lt, 3 ltu, 4 ge, 5 geu) |
| use_imm | input | 1 | Take the second operand from the immediate |
| swap | input | 1 | Exchange the operands before evaluation |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| res | output | 32 | Registered flag word, 1 or 0 |
| res_valid | output | 1 | Result on res is new this cycle |

## Verification
The bench sweeps every relation code, with and without swap, over operands that sit on the signed and unsigned boundaries: 0, 1, -1, the most positive and most negative words, and values around bit 15. A unit that derived the signed order wrongly would give the same answer for signed and unsigned less-than on 0x80000000 versus 1. A unit that used the wrong immediate extension would disagree on 0x8000 against 0xFFFF8000 or 0x00008000. A unit that swapped before forming the immediate would compare against the register operand instead of the immediate. The bench also checks that unassigned codes give 0, that idle cycles hold the result, and that reset clears both outputs.

// File: rtl/cmpset_pkg.sv
package cmpset_pkg;
  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_LT  = 3'd2,
    REL_LTU = 3'd3,
    REL_GE  = 3'd4,
    REL_GEU = 3'd5
  } rel_e;

  // Unsigned relations take a zero-extended immediate.
  function automatic logic rel_is_unsigned(input logic [2:0] code);
    return (code == REL_LTU) || (code == REL_GEU);
  endfunction
endpackage

// File: rtl/cmpset_opsel.sv
module cmpset_opsel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             zext,
  input  logic             swap,
  output logic [WIDTH-1:0] cmp_x,
  output logic [WIDTH-1:0] cmp_y
);
  localparam int EXT_W = WIDTH - IMM_W;

  function automatic logic [WIDTH-1:0] widen(input logic [IMM_W-1:0] v, input logic z);
    logic fill;
    fill = z ? 1'b0 : v[IMM_W-1];
    return {{EXT_W{fill}}, v};
  endfunction

  logic [WIDTH-1:0] second_w;
  assign second_w = use_imm ? widen(imm, zext) : opb;
  assign cmp_x    = swap ? second_w : opa;
  assign cmp_y    = swap ? opa : second_w;

  // R6
  zext_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (use_imm && zext) |-> (second_w[WIDTH-1:IMM_W] == '0));
  // R5
  sext_upper_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (use_imm && !zext) |-> (second_w[WIDTH-1:IMM_W] == {EXT_W{imm[IMM_W-1]}}));
  // R7
  swap_pairing_chk: assert property (@(posedge clk) disable iff (rst)
    swap |-> (cmp_y == opa));
endmodule

// File: rtl/cmpset_core.sv
module cmpset_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [2:0]       rel,
  output logic             hit
);
  import cmpset_pkg::*;

  localparam int MSB = WIDTH - 1;

  function automatic logic signed_less(input logic sx, input logic sy, input logic ult);
    return (sx != sy) ? sx : ult;
  endfunction

  logic eq_w, ltu_w, lts_w;
  assign eq_w  = (x == y);
  assign ltu_w = (x < y);
  assign lts_w = signed_less(x[MSB], y[MSB], ltu_w);

  always_comb begin
    case (rel)
      REL_EQ:  hit = eq_w;
      REL_NE:  hit = !eq_w;
      REL_LT:  hit = lts_w;
      REL_LTU: hit = ltu_w;
      REL_GE:  hit = !lts_w;
      REL_GEU: hit = !ltu_w;
      default: hit = 1'b0;
    endcase
  end

  // R2
  eq_excludes_less_chk: assert property (@(posedge clk) disable iff (rst)
    eq_w |-> (!ltu_w && !lts_w));
  // R3
  neg_below_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (x[MSB] && !y[MSB]) |-> (lts_w && !ltu_w));
  // R8
  unassigned_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rel > 3'd5) |-> !hit);
endmodule

// File: rtl/cmpset_unit.sv
module cmpset_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       rel,
  input  logic             use_imm,
  input  logic             swap,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] res,
  output logic             res_valid
);
  import cmpset_pkg::*;

  logic [WIDTH-1:0] cmp_x, cmp_y;
  logic             zext_w, hit_w;

  assign zext_w = rel_is_unsigned(rel);

  cmpset_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .imm(imm),
    .use_imm(use_imm), .zext(zext_w), .swap(swap),
    .cmp_x(cmp_x), .cmp_y(cmp_y)
  );

  cmpset_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .x(cmp_x), .y(cmp_y), .rel(rel), .hit(hit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= {{(WIDTH-1){1'b0}}, hit_w};
    end
  end

  // R1
  flag_word_chk: assert property (@(posedge clk) disable iff (rst)
    res[WIDTH-1:1] == '0);
  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(in_valid && !rst));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res));
endmodule

// File: tb/cmpset_unit_tb.sv
module cmpset_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  rel;
  logic        use_imm, swap;
  logic [31:0] opa, opb;
  logic [15:0] imm;
  logic [31:0] res;
  logic        res_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmpset_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rel(rel), .use_imm(use_imm),
    .swap(swap), .opa(opa), .opb(opb), .imm(imm), .res(res), .res_valid(res_valid)
  );

  logic [31:0] wvals [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'h0000_8000, 32'hFFFF_8000, 32'h0000_7FFF, 32'h2, 32'h0000_FFFF};
  logic [15:0] ivals [6]  = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h2};

  function automatic logic [31:0] model(input logic [2:0] r, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic ui, input logic sw);
    logic [31:0] second, x, y;
    logic t;
    if (!ui) second = b;
    else if (r == 3'd3 || r == 3'd5) second = {16'h0, im};
    else second = {{16{im[15]}}, im};
    x = sw ? second : a;
    y = sw ? a : second;
    case (r)
      3'd0: t = (x == y);
      3'd1: t = (x != y);
      3'd2: t = ($signed(x) < $signed(y));
      3'd3: t = (x < y);
      3'd4: t = ($signed(x) >= $signed(y));
      3'd5: t = (x >= y);
      default: t = 1'b0;
    endcase
    return {31'h0, t};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] r, input logic ui, input logic sw);
    if (sw) return "R7";
    if (r > 3'd5) return "R8";
    if (ui) return (r == 3'd3 || r == 3'd5) ? "R6" : "R5";
    if (r < 3'd2) return "R2";
    if (r == 3'd2 || r == 3'd4) return "R3";
    return "R4";
  endfunction

  task automatic apply(input logic [2:0] r, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] im, input logic ui, input logic sw);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = 1'b1; rel = r; opa = a; opb = b; imm = im; use_imm = ui; swap = sw;
    exp = model(r, a, b, im, ui, sw);
    @(negedge clk);
    check(tag_of(r, ui, sw), res, exp);
    check("R1", {res[31:1], 1'b0}, 32'h0);
    check("R9", {31'h0, res_valid}, 32'h1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; rel = 3'd0; use_imm = 1'b0; swap = 1'b0;
    opa = '0; opb = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R10", res, 32'h0);
    check("R10", {31'h0, res_valid}, 32'h0);
    rst = 1'b0;

    for (int r = 0; r < 8; r++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 10; i++) begin
          for (int j = 0; j < 10; j++)
            apply(3'(r), wvals[i], wvals[j], 16'h0, 1'b0, s[0]);
          for (int k = 0; k < 6; k++)
            apply(3'(r), wvals[i], 32'hDEAD_BEEF, ivals[k], 1'b1, s[0]);
        end

    // R9: idle cycle holds a result of 1 despite changed operands
    apply(3'd0, 32'h5, 32'h5, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; opb = 32'h6; rel = 3'd0;
    @(negedge clk);
    check("R9", res, 32'h1);
    check("R9", {31'h0, res_valid}, 32'h0);

    // R10: mid-run reset clears a set result
    apply(3'd2, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R10", res, 32'h0);
    check("R10", {31'h0, res_valid}, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule